// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block turns the window registers of a type-1 bridge configuration header into full-width address ranges. It reads those registers one byte at a time through a read port into the configuration register file. It then presents three decoded windows: I/O, memory and prefetchable memory. Each window has a base address, a limit address, a size and a valid flag. Forwarding logic elsewhere in the bridge compares transaction addresses against these ranges.

The block sweeps the 22 window bytes in a fixed order, one byte per clock, and keeps a shadow copy of them. A complete sweep is transferred to the decoded outputs in a single step, so a window never shows a mix of old and new register bytes. The outputs are decoded combinationally from that committed copy. The upper address halves are used only when a register's type nibble advertises wide addressing. A window whose base lies above its limit is reported as unmapped.

Top module: `bridge_window_decoder`

## Requirements
- R1: After reset `cfgAddr` presents byte offsets 0x1C, 0x1D, 0x20, 0x21, ... 0x33 in that order, one per clock. It returns to 0x1C after 0x33 and repeats this 22-step sweep indefinitely.
- R2: The decoded outputs change only on the clock edge that samples offset 0x33. At that edge all 22 bytes from the sweep that just ended take effect together. Between those edges the outputs hold even if register contents change.
- R3: I/O base equals byte 0x1C bits 7:4 placed at address bits 15:12, with bits 11:0 zero. Bits 31:16 come from the little-endian half-word at 0x30..0x31 only when byte 0x1C bits 3:0 equal 1; otherwise they are zero.
- R4: I/O limit equals byte 0x1D bits 7:4 at address bits 15:12, with bits 11:0 all ones. Bits 31:16 come from the half-word at 0x32..0x33 only when byte 0x1D bits 3:0 equal 1; otherwise they are zero.
- R5: Memory base and limit take bits 15:4 of the little-endian words at 0x20 and 0x22 as address bits 31:20. Bits 19:0 are zero for the base and all ones for the limit. Bits 3:0 of both words have no effect.
- R6: Prefetchable base and limit take bits 15:4 of the words at 0x24 and 0x26 as address bits 31:20. Bits 19:0 are zero for the base and all ones for the limit. Bits 63:32 come from the little-endian words at 0x28..0x2B and 0x2C..0x2F only when bits 3:0 of the word at 0x24 (for the base) or 0x26 (for the limit) equal 1; otherwise they are zero.
- R7: When a window's base is not above its limit, its valid flag is 1 and its size equals limit minus base plus one. The size is one bit wider than the address, so a full-range window does not wrap.
- R8: When a window's base is above its limit, its valid flag is 0, its base and limit outputs are all ones, and its size is zero.
- R9: After reset and before the first sweep completes, the outputs decode all-zero registers. This gives the I/O window 0..0xFFF with size 0x1000, and both memory windows 0..0xFFFFF with size 0x100000, all valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | output | 8 | Byte offset being read from the configuration register file |
| cfgData | input | 8 | Byte at `cfgAddr`, same cycle |
| ioBase | output | 32 | Decoded I/O window base |
| ioLimit | output | 32 | Decoded I/O window limit |
| ioSize | output | 33 | I/O window size |
| ioValid | output | 1 | I/O window active |
| memBase | output | 32 | Decoded memory window base |
| memLimit | output | 32 | Decoded memory window limit |
| memSize | output | 33 | Memory window size |
| memValid | output | 1 | Memory window active |
| pfBase | output | 64 | Decoded prefetchable window base |
| pfLimit | output | 64 | Decoded prefetchable window limit |
| pfSize | output | 65 | Prefetchable window size |
| pfValid | output | 1 | Prefetchable window active |

## Verification
Register images are tried in several forms, each compared against a behavioural model on every clock. One image has non-zero upper registers but narrow type nibbles, which shows whether the upper halves are gated by type. Another sets the type nibbles to wide, which shows they are actually used. A third uses mixed type nibbles where only the base is wide, and a fourth sets base above limit, which separates valid from unmapped handling. Further cases cover noisy low nibbles on the memory words, equal base and limit, and a full-range prefetchable window that shows the size does not wrap. A separate run changes the registers at the start of a sweep and confirms the outputs hold for 21 clocks and then switch all at once.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int unsigned NBYTES = 22;
  localparam int unsigned IDXW   = $clog2(NBYTES);
  localparam int unsigned IO_W   = 32;
  localparam int unsigned MEM_W  = 32;
  localparam int unsigned PF_W   = 64;

  // shadow byte indices
  localparam int unsigned IX_IOB    = 0;
  localparam int unsigned IX_IOL    = 1;
  localparam int unsigned IX_MEMB   = 2;
  localparam int unsigned IX_MEML   = 4;
  localparam int unsigned IX_PFB    = 6;
  localparam int unsigned IX_PFL    = 8;
  localparam int unsigned IX_PFBUP  = 10;
  localparam int unsigned IX_PFLUP  = 14;
  localparam int unsigned IX_IOBUP  = 18;
  localparam int unsigned IX_IOLUP  = 20;

  localparam logic [3:0] WIDE_CODE = 4'h1;

  typedef struct packed {
    logic            capture;
    logic            commit;
    logic [IDXW-1:0] idx;
  } scanCtl_t;

  function automatic logic [7:0] scanOffset(input logic [IDXW-1:0] i);
    if (i < IDXW'(2)) return 8'h1C + 8'(i);
    return 8'h1E + 8'(i);
  endfunction
endpackage

// File: rtl/bwd_ctrl.sv
module bwd_ctrl
  import bwd_pkg::*;
#(
  parameter int unsigned CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [CFG_AW-1:0] cfgAddr,
  output scanCtl_t          ctl
);
  logic [IDXW-1:0] idx;
  logic            atEnd;

  assign atEnd = (idx == IDXW'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) idx <= '0;
    else if (atEnd) idx <= '0;
    else idx <= idx + IDXW'(1);
  end

  always_comb begin
    ctl.capture = 1'b1;
    ctl.commit  = atEnd;
    ctl.idx     = idx;
    cfgAddr     = CFG_AW'(scanOffset(idx));
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    idx < IDXW'(NBYTES)); // R1
  AST_SWEEP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    atEnd |=> (idx == '0)); // R1
endmodule

// File: rtl/bwd_regs.sv
module bwd_regs
  import bwd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  scanCtl_t               ctl,
  input  logic [7:0]             cfgData,
  output logic [NBYTES-1:0][7:0] committed
);
  logic [NBYTES-1:0][7:0] shadow;
  logic [NBYTES-1:0][7:0] shadowNext;

  always_comb begin
    shadowNext = shadow;
    for (int i = 0; i < NBYTES; i++) begin
      if (ctl.capture && (ctl.idx == IDXW'(i))) shadowNext[i] = cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow    <= '0;
      committed <= '0;
    end else begin
      shadow <= shadowNext;
      if (ctl.commit) committed <= shadowNext;
    end
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> $stable(committed)); // R2
endmodule

// File: rtl/bwd_window.sv
module bwd_window #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rawBase,
  input  logic [W-1:0] rawLimit,
  output logic [W-1:0] base,
  output logic [W-1:0] limit,
  output logic [W:0]   size,
  output logic         valid
);
  always_comb begin
    valid = (rawBase <= rawLimit);
    if (valid) begin
      base  = rawBase;
      limit = rawLimit;
      size  = {1'b0, rawLimit} - {1'b0, rawBase} + (W+1)'(1);
    end else begin
      base  = '1;
      limit = '1;
      size  = '0;
    end
  end
endmodule

// File: rtl/bwd_decode.sv
module bwd_decode
  import bwd_pkg::*;
(
  input  logic [NBYTES-1:0][7:0] b,
  output logic [IO_W-1:0]        ioBase,
  output logic [IO_W-1:0]        ioLimit,
  output logic [IO_W:0]          ioSize,
  output logic                   ioValid,
  output logic [MEM_W-1:0]       memBase,
  output logic [MEM_W-1:0]       memLimit,
  output logic [MEM_W:0]         memSize,
  output logic                   memValid,
  output logic [PF_W-1:0]        pfBase,
  output logic [PF_W-1:0]        pfLimit,
  output logic [PF_W:0]          pfSize,
  output logic                   pfValid
);
  logic [15:0]      memBw, memLw, pfBw, pfLw, ioBup, ioLup;
  logic [31:0]      pfBup, pfLup;
  logic             ioWideB, ioWideL, pfWideB, pfWideL;
  logic [IO_W-1:0]  ioRawB, ioRawL;
  logic [MEM_W-1:0] memRawB, memRawL;
  logic [PF_W-1:0]  pfRawB, pfRawL;

  always_comb begin
    memBw = {b[IX_MEMB+1], b[IX_MEMB]};
    memLw = {b[IX_MEML+1], b[IX_MEML]};
    pfBw  = {b[IX_PFB+1],  b[IX_PFB]};
    pfLw  = {b[IX_PFL+1],  b[IX_PFL]};
    ioBup = {b[IX_IOBUP+1], b[IX_IOBUP]};
    ioLup = {b[IX_IOLUP+1], b[IX_IOLUP]};
    pfBup = {b[IX_PFBUP+3], b[IX_PFBUP+2], b[IX_PFBUP+1], b[IX_PFBUP]};
    pfLup = {b[IX_PFLUP+3], b[IX_PFLUP+2], b[IX_PFLUP+1], b[IX_PFLUP]};

    ioWideB = (b[IX_IOB][3:0] == WIDE_CODE);
    ioWideL = (b[IX_IOL][3:0] == WIDE_CODE);
    pfWideB = (pfBw[3:0] == WIDE_CODE);
    pfWideL = (pfLw[3:0] == WIDE_CODE);

    ioRawB  = {(ioWideB ? ioBup : 16'h0), b[IX_IOB][7:4], 12'h000};
    ioRawL  = {(ioWideL ? ioLup : 16'h0), b[IX_IOL][7:4], 12'hFFF};
    memRawB = {memBw[15:4], 20'h00000};
    memRawL = {memLw[15:4], 20'hFFFFF};
    pfRawB  = {(pfWideB ? pfBup : 32'h0), pfBw[15:4], 20'h00000};
    pfRawL  = {(pfWideL ? pfLup : 32'h0), pfLw[15:4], 20'hFFFFF};
  end

  bwd_window #(.W(IO_W)) uIoWin (
    .rawBase(ioRawB), .rawLimit(ioRawL),
    .base(ioBase), .limit(ioLimit), .size(ioSize), .valid(ioValid));

  bwd_window #(.W(MEM_W)) uMemWin (
    .rawBase(memRawB), .rawLimit(memRawL),
    .base(memBase), .limit(memLimit), .size(memSize), .valid(memValid));

  bwd_window #(.W(PF_W)) uPfWin (
    .rawBase(pfRawB), .rawLimit(pfRawL),
    .base(pfBase), .limit(pfLimit), .size(pfSize), .valid(pfValid));
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
#(
  parameter int unsigned CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgData,
  output logic [31:0]       ioBase,
  output logic [31:0]       ioLimit,
  output logic [32:0]       ioSize,
  output logic              ioValid,
  output logic [31:0]       memBase,
  output logic [31:0]       memLimit,
  output logic [32:0]       memSize,
  output logic              memValid,
  output logic [63:0]       pfBase,
  output logic [63:0]       pfLimit,
  output logic [64:0]       pfSize,
  output logic              pfValid
);
  scanCtl_t               ctl;
  logic [NBYTES-1:0][7:0] committed;

  bwd_ctrl #(.CFG_AW(CFG_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .ctl(ctl));

  bwd_regs uRegs (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgData(cfgData),
    .committed(committed));

  bwd_decode uDec (
    .b(committed),
    .ioBase(ioBase), .ioLimit(ioLimit), .ioSize(ioSize), .ioValid(ioValid),
    .memBase(memBase), .memLimit(memLimit), .memSize(memSize), .memValid(memValid),
    .pfBase(pfBase), .pfLimit(pfLimit), .pfSize(pfSize), .pfValid(pfValid));

  AST_WIN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> (pfLimit >= pfBase)); // R7
  AST_UNMAPPED_IO: assert property (@(posedge clk) disable iff (!rstN)
    !ioValid |-> (ioSize == '0 && ioBase == '1 && ioLimit == '1)); // R8
  AST_IO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    ioValid |-> (ioLimit[11:0] == 12'hFFF && ioBase[11:0] == 12'h000)); // R4
  AST_MEM_FILL: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memBase[19:0] == 20'h0 && memLimit[19:0] == 20'hFFFFF)); // R5
endmodule

// File: tb/sim_bridge_window_decoder.sv
module sim_bridge_window_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  cfgAddr, cfgData;
  logic [31:0] ioBase, ioLimit, memBase, memLimit;
  logic [32:0] ioSize, memSize;
  logic [63:0] pfBase, pfLimit;
  logic [64:0] pfSize;
  logic        ioValid, memValid, pfValid;

  logic [7:0] mem [256];
  assign cfgData = mem[cfgAddr];

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  bridge_window_decoder u0 (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .ioBase(ioBase), .ioLimit(ioLimit), .ioSize(ioSize), .ioValid(ioValid),
    .memBase(memBase), .memLimit(memLimit), .memSize(memSize), .memValid(memValid),
    .pfBase(pfBase), .pfLimit(pfLimit), .pfSize(pfSize), .pfValid(pfValid));

  // expected values
  logic [31:0] eIoB, eIoL, eMemB, eMemL;
  logic [32:0] eIoS, eMemS;
  logic [63:0] ePfB, ePfL;
  logic [64:0] ePfS;
  logic        eIoV, eMemV, ePfV;

  function automatic longint unsigned rd(bit zero, int a);
    return zero ? 64'd0 : 64'(mem[a]);
  endfunction

  task automatic model(input bit zero);
    longint unsigned rb, rl, w;
    // I/O window (R3, R4)
    rb = (rd(zero, 'h1C) >> 4) * 4096;
    if ((rd(zero, 'h1C) & 15) == 1) rb += (rd(zero, 'h30) + 256 * rd(zero, 'h31)) * 65536;
    rl = (rd(zero, 'h1D) >> 4) * 4096 + 4095;
    if ((rd(zero, 'h1D) & 15) == 1) rl += (rd(zero, 'h32) + 256 * rd(zero, 'h33)) * 65536;
    eIoV = (rb <= rl);
    eIoB = eIoV ? 32'(rb) : 32'hFFFF_FFFF;
    eIoL = eIoV ? 32'(rl) : 32'hFFFF_FFFF;
    eIoS = eIoV ? 33'(rl - rb + 1) : 33'd0;
    // memory window (R5)
    w  = rd(zero, 'h20) + 256 * rd(zero, 'h21);
    rb = (w >> 4) * 1048576;
    w  = rd(zero, 'h22) + 256 * rd(zero, 'h23);
    rl = (w >> 4) * 1048576 + 1048575;
    eMemV = (rb <= rl);
    eMemB = eMemV ? 32'(rb) : 32'hFFFF_FFFF;
    eMemL = eMemV ? 32'(rl) : 32'hFFFF_FFFF;
    eMemS = eMemV ? 33'(rl - rb + 1) : 33'd0;
    // prefetchable window (R6)
    w  = rd(zero, 'h24) + 256 * rd(zero, 'h25);
    rb = (w >> 4) * 1048576;
    if ((w & 15) == 1)
      rb += (rd(zero, 'h28) + (rd(zero, 'h29) << 8) + (rd(zero, 'h2A) << 16) + (rd(zero, 'h2B) << 24)) << 32;
    w  = rd(zero, 'h26) + 256 * rd(zero, 'h27);
    rl = (w >> 4) * 1048576 + 1048575;
    if ((w & 15) == 1)
      rl += (rd(zero, 'h2C) + (rd(zero, 'h2D) << 8) + (rd(zero, 'h2E) << 16) + (rd(zero, 'h2F) << 24)) << 32;
    ePfV = (rb <= rl);
    ePfB = ePfV ? rb : 64'hFFFF_FFFF_FFFF_FFFF;
    ePfL = ePfV ? rl : 64'hFFFF_FFFF_FFFF_FFFF;
    ePfS = ePfV ? ({1'b0, rl} - {1'b0, rb} + 65'd1) : 65'd0;
  endtask

  task automatic checkAll(input string tag);
    tests += 3;
    if ({ioBase, ioLimit, ioSize, ioValid} !== {eIoB, eIoL, eIoS, eIoV}) begin
      fails++;
      $display("FAIL %s io: got %h/%h/%h/%b exp %h/%h/%h/%b", tag,
               ioBase, ioLimit, ioSize, ioValid, eIoB, eIoL, eIoS, eIoV);
    end
    if ({memBase, memLimit, memSize, memValid} !== {eMemB, eMemL, eMemS, eMemV}) begin
      fails++;
      $display("FAIL %s mem: got %h/%h/%h/%b exp %h/%h/%h/%b", tag,
               memBase, memLimit, memSize, memValid, eMemB, eMemL, eMemS, eMemV);
    end
    if ({pfBase, pfLimit, pfSize, pfValid} !== {ePfB, ePfL, ePfS, ePfV}) begin
      fails++;
      $display("FAIL %s pf: got %h/%h/%h/%b exp %h/%h/%h/%b", tag,
               pfBase, pfLimit, pfSize, pfValid, ePfB, ePfL, ePfS, ePfV);
    end
  endtask

  task automatic setWord(input int a, input logic [15:0] v);
    mem[a] = v[7:0]; mem[a+1] = v[15:8];
  endtask

  task automatic setLong(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[a+k] = v[8*k +: 8];
  endtask

  task automatic settleAndCheck(input string tag);
    repeat (50) @(posedge clk);
    model(1'b0);
    for (int k = 0; k < 22; k++) begin
      @(negedge clk);
      checkAll(tag);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R9: zero-decoded state before first commit
    model(1'b1);
    checkAll("R9");

    // R1: scan order over two sweeps
    for (int k = 0; k < 44; k++) begin
      tests++;
      if (cfgAddr !== ((k % 22) < 2 ? 8'(8'h1C + (k % 22)) : 8'(8'h1E + (k % 22)))) begin
        fails++;
        $display("FAIL R1 step %0d: got %h exp %h", k, cfgAddr,
                 (k % 22) < 2 ? 8'(8'h1C + (k % 22)) : 8'(8'h1E + (k % 22)));
      end
      @(negedge clk);
    end

    // narrow types, upper registers non-zero and ignored (R3 R4 R5 R6 R7)
    mem['h1C] = 8'h40; mem['h1D] = 8'h70;
    setWord('h20, 16'h1230); setWord('h22, 16'h1560);
    setWord('h24, 16'h8000); setWord('h26, 16'h9FF0);
    setLong('h28, 32'hDEAD_0001); setLong('h2C, 32'hDEAD_0002);
    setWord('h30, 16'hAAAA); setWord('h32, 16'hBBBB);
    settleAndCheck("R3/R4/R6/R7 narrow");

    // wide types use upper halves (R3 R4 R6 R7)
    mem['h1C] = 8'h21; mem['h1D] = 8'hE1;
    setWord('h30, 16'h0002); setWord('h32, 16'h0003);
    setWord('h24, 16'h0011); setWord('h26, 16'h0051);
    setLong('h28, 32'h0000_0010); setLong('h2C, 32'h0000_0020);
    settleAndCheck("R3/R4/R6/R7 wide");

    // noisy low nibbles on memory words, equal base and limit (R5 R7)
    setWord('h20, 16'h777F); setWord('h22, 16'h7775);
    mem['h1C] = 8'h30; mem['h1D] = 8'h30;
    settleAndCheck("R5/R7 equal");

    // base above limit on all three (R8)
    mem['h1C] = 8'h90; mem['h1D] = 8'h10;
    setWord('h20, 16'h4000); setWord('h22, 16'h3FF0);
    setWord('h24, 16'h0011); setWord('h26, 16'hFFF0);
    setLong('h28, 32'h1); setLong('h2C, 32'hFFFF_FFFF);
    settleAndCheck("R8 inverted");

    // mixed widths: wide base, narrow limit -> unmapped (R3 R4 R8)
    mem['h1C] = 8'h01; mem['h1D] = 8'hF0; setWord('h30, 16'h0001);
    setWord('h20, 16'h0000); setWord('h22, 16'hFFF0);
    setWord('h24, 16'h0001); setWord('h26, 16'hFFF1);
    setLong('h28, 32'h0); setLong('h2C, 32'hFFFF_FFFF);
    settleAndCheck("R3/R4/R8 mixed, R7 full range");

    // R2: outputs hold through a sweep, then switch together
    @(negedge clk);
    while (cfgAddr !== 8'h1C) @(negedge clk);
    model(1'b0);
    mem['h1C] = 8'h50; mem['h1D] = 8'hA0;
    setWord('h20, 16'h2000); setWord('h22, 16'h2FF0);
    setWord('h24, 16'h0100); setWord('h26, 16'h01F0);
    for (int k = 0; k < 21; k++) begin
      @(negedge clk);
      checkAll("R2 hold");
    end
    model(1'b0);
    @(negedge clk);
    checkAll("R2 switch");

    done = 1'b1;
    finishRun();
  end
endmodule